// File: doc/BRIEF.md
# APB Down-Counting Reload Timer

This block is a 32-bit timer attached to an APB slave port. Software loads a start value, enables counting, and the counter steps down once per count tick. When it steps from 1 to 0 it raises an expiry event. It then stays at 0 for one more tick and reloads on the tick after that, so a reload value N gives a period of N+1 ticks. Each expiry can latch a level interrupt flag, which software clears by writing a 1.

A count tick is normally every PCLK cycle. An external input, passed through a synchronizer, can instead supply the ticks: in clock mode each of its rising edges is one tick. In gate mode counting is held off while the input is low. Both modes can be active together. A block of read-only identification words sits at the top of the 4 KB window.

The bus port has no back-pressure: PREADY is always high, so every access completes in its access phase. The data path carries no stream, so no valid/ready handshake is used. A write takes effect at the clock edge that ends the access phase. Read data is driven combinationally during that phase.

Top module: `apb_reload_timer`

## Requirements
- R1: After reset, the control, count, reload and status registers read 0, irq_out is 0 and pready is 1.
- R2: The control word is at byte offset 0x0 and stores only bits [3:0]: bit 0 run, bit 1 external gate, bit 2 external clock, bit 3 interrupt enable. Bits [31:4] read as 0.
- R3: The count is at offset 0x4 and the reload value at 0x8. A write to 0x8 loads the written value into both reload and count. A write to 0x4 loads only the count.
- R4: With run set and both external modes clear, the count drops by one every PCLK cycle. A step from 1 to 0 with interrupt enable set raises the flag, and irq_out equals the flag. A reload of N started from count N raises irq_out N cycles after the control write edge.
- R5: After reaching 0 the count holds at 0 for one tick, then loads the reload value. Successive expiries are therefore reload+1 ticks apart.
- R6: With reload 0, the count stays at 0 after an expiry and no further flag is raised.
- R7: The status flag is bit 0 at offset 0xC. Writing 1 to that bit clears it and writing 0 leaves it unchanged. An expiry in the same cycle as a clear wins.
- R8: With interrupt enable clear, an expiry does not set the flag.
- R9: In gate mode, no tick occurs while the synchronized external input is low. An input held high across K clock edges yields K ticks.
- R10: In clock mode, each rising edge of the synchronized external input yields exactly one tick, independent of the PCLK rate.
- R11: With run clear, the count is frozen. A software write to count or reload takes priority over a tick in the same cycle.
- R12: Offsets 0xFD0 to 0xFFC read, in ascending order, 0x04, 0x00, 0x00, 0x00, 0x22, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to them have no effect. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 10 | Word address, byte address bits [11:2] |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1, no wait states |
| ext_sig | input | 1 | Asynchronous external gate or count clock |
| irq_out | output | 1 | Level interrupt, equal to the status flag |

## Verification
The counter is driven by three tick sources: free-running PCLK, a gated external level held high for a known number of edges, and a pulse train of external rising edges. Only the right source-specific tick count (6 left of 10, 15 left of 20) separates gating from edge counting and from plain PCLK counting. Expiry timing is measured in cycles against reload values of 5 and 0, which tells the 1-to-0 trigger, the one-tick hold at zero and the silent zero reload apart. A value write issued while counting, followed by a stop, gives a remainder that shows whether the write or the decrement won that cycle.

// File: rtl/apb_tmr_pkg.sv
package apb_tmr_pkg;
  localparam int unsigned IDX_W = 10;

  localparam logic [IDX_W-1:0] IDX_CTRL     = 10'h000;
  localparam logic [IDX_W-1:0] IDX_COUNT    = 10'h001;
  localparam logic [IDX_W-1:0] IDX_RELOAD   = 10'h002;
  localparam logic [IDX_W-1:0] IDX_FLAG     = 10'h003;
  localparam logic [IDX_W-1:0] IDX_ID_FIRST = 10'h3F4;

  typedef struct packed {
    logic irq_en;    // bit 3
    logic ext_clk;   // bit 2
    logic ext_gate;  // bit 1
    logic run;       // bit 0
  } tmr_ctrl_t;

  // identification byte selected by the low nibble of the word index (4..15)
  function automatic logic [7:0] id_byte(input logic [3:0] nib);
    case (nib)
      4'h4: id_byte = 8'h04;
      4'h8: id_byte = 8'h22;
      4'h9: id_byte = 8'hB8;
      4'hA: id_byte = 8'h1B;
      4'hC: id_byte = 8'h0D;
      4'hD: id_byte = 8'hF0;
      4'hE: id_byte = 8'h05;
      4'hF: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/apb_tmr_sync.sv
module apb_tmr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= 1'b0;
    else        pipe[0] <= async_in;
  end

  for (genvar gi = 1; gi <= STAGES; gi++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[gi] <= 1'b0;
      else        pipe[gi] <= pipe[gi-1];
    end
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];

  assert_single_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/apb_tmr_counter.sv
module apb_tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_count,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic sw_load;
  assign sw_load = wr_count | wr_reload;
  assign expire  = tick && !sw_load && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
    end else begin
      if (wr_reload) reload <= wdata;
      if (sw_load)
        count <= wdata;
      else if (tick) begin
        if (count == '0) count <= reload;
        else             count <= count - ONE;
      end
    end
  end

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sw_load && count > ONE) |=> count == $past(count) - ONE);

  assert_hold_then_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sw_load && count == '0) |=> count == $past(reload));

  assert_zero_reload_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sw_load && count == '0 && reload == '0) |=> (count == '0));

  assert_reload_loads_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reload |=> (count == $past(wdata)) && (reload == $past(wdata)));

  assert_write_beats_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_count && tick) |=> count == $past(wdata));

  assert_frozen_without_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sw_load) |=> $stable(count));
endmodule

// File: rtl/apb_tmr_regs.sv
module apb_tmr_regs
  import apb_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [IDX_W-1:0]  paddr,
  input  logic [3:0]        wdata_lo,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  reload,
  input  logic              expire,
  output tmr_ctrl_t         ctrl_q,
  output logic              flag_q,
  output logic              wr_count,
  output logic              wr_reload,
  output logic [DATA_W-1:0] prdata
);
  logic wr_acc, wr_ctrl, wr_flag, flag_set;

  assign wr_acc    = psel && penable && pwrite;
  assign wr_ctrl   = wr_acc && (paddr == IDX_CTRL);
  assign wr_count  = wr_acc && (paddr == IDX_COUNT);
  assign wr_reload = wr_acc && (paddr == IDX_RELOAD);
  assign wr_flag   = wr_acc && (paddr == IDX_FLAG);
  assign flag_set  = expire && ctrl_q.irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wdata_lo);
      if (flag_set)                  flag_q <= 1'b1;
      else if (wr_flag && wdata_lo[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    if (paddr >= IDX_ID_FIRST)
      prdata = DATA_W'(id_byte(paddr[3:0]));
    else begin
      case (paddr)
        IDX_CTRL:   prdata = DATA_W'(ctrl_q);
        IDX_COUNT:  prdata = DATA_W'(count);
        IDX_RELOAD: prdata = DATA_W'(reload);
        IDX_FLAG:   prdata = DATA_W'(flag_q);
        default:    prdata = '0;
      endcase
    end
  end

  assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && paddr == IDX_CTRL) |-> (prdata[DATA_W-1:4] == '0));

  assert_flag_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && wdata_lo[0] && !expire) |=> !flag_q);

  assert_flag_write0_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && !wdata_lo[0] && flag_q) |=> flag_q);

  assert_flag_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(expire && ctrl_q.irq_en));
endmodule

// File: rtl/apb_reload_timer.sv
module apb_reload_timer
  import apb_tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [9:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  input  logic        ext_sig,
  output logic        irq_out
);
  localparam int unsigned DATA_W = 32;

  tmr_ctrl_t        ctrl_q;
  logic             flag_q, wr_count, wr_reload, expire;
  logic             ext_level, ext_rise, tick;
  logic [CNT_W-1:0] count, reload;

  apb_tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(pclk), .rst_n(presetn), .async_in(ext_sig),
    .level(ext_level), .rise(ext_rise)
  );

  assign tick = ctrl_q.run
              && (!ctrl_q.ext_clk  || ext_rise)
              && (!ctrl_q.ext_gate || ext_level);

  apb_tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(pclk), .rst_n(presetn), .tick(tick),
    .wr_count(wr_count), .wr_reload(wr_reload), .wdata(pwdata[CNT_W-1:0]),
    .count(count), .reload(reload), .expire(expire)
  );

  apb_tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .wdata_lo(pwdata[3:0]),
    .count(count), .reload(reload), .expire(expire),
    .ctrl_q(ctrl_q), .flag_q(flag_q), .wr_count(wr_count),
    .wr_reload(wr_reload), .prdata(prdata)
  );

  assign pready  = 1'b1;
  assign irq_out = flag_q;

  assert_gate_blocks_R9: assert property (@(posedge pclk) disable iff (!presetn)
    (ctrl_q.ext_gate && !ext_level && !wr_count && !wr_reload) |=> $stable(count));

  assert_no_run_no_flag_R8: assert property (@(posedge pclk) disable iff (!presetn)
    (!ctrl_q.run && !irq_out) |=> !irq_out);
endmodule

// File: tb/apb_reload_timer_tb.sv
`timescale 1ns/1ps
module apb_reload_timer_tb;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, irq_out;
  logic        ext_sig = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 pclk = ~pclk;

  apb_reload_timer u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .ext_sig(ext_sig), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a[11:2]; pwdata = d; penable = 1'b0;
    @(negedge pclk); penable = 1'b1;
    @(posedge pclk); @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a[11:2]; penable = 1'b0;
    @(negedge pclk); penable = 1'b1;
    #1 d = prdata;
    @(posedge pclk); @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq_out && n < 200) begin
      @(posedge pclk); @(negedge pclk); n++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge pclk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 pready", {31'b0, pready}, 32'd1);
    check("R1 irq_out", {31'b0, irq_out}, 32'd0);
    apb_read(12'h000, d); check("R1 ctrl", d, 32'h0);
    apb_read(12'h004, d); check("R1 count", d, 32'h0);
    apb_read(12'h008, d); check("R1 reload", d, 32'h0);
    apb_read(12'h00C, d); check("R1 status", d, 32'h0);
  endtask

  task automatic t_ctrl_bits;
    logic [31:0] d;
    apb_write(12'h000, 32'hFFFF_FFF6);
    apb_read(12'h000, d); check("R2 ctrl stores 4 bits", d, 32'h6);
    apb_write(12'h000, 32'h0);
  endtask

  task automatic t_load;
    logic [31:0] d;
    apb_write(12'h008, 32'h0000_1234);
    apb_read(12'h004, d); check("R3 reload write loads count", d, 32'h1234);
    apb_read(12'h008, d); check("R3 reload value", d, 32'h1234);
    apb_write(12'h004, 32'h0000_0055);
    apb_read(12'h004, d); check("R3 count write", d, 32'h55);
    apb_read(12'h008, d); check("R3 reload untouched by count write", d, 32'h1234);
  endtask

  task automatic t_periodic;
    int n;
    logic [31:0] d, d2;
    apb_write(12'h008, 32'd5);
    apb_write(12'h000, 32'h9);
    wait_irq(n);
    check("R4 cycles to first expiry", n, 32'd5);
    apb_write(12'h00C, 32'h1);          // two edges consumed
    check("R7 write 1 clears flag", {31'b0, irq_out}, 32'd0);
    wait_irq(n);
    check("R5 period reload+1 (minus 2 spent)", n, 32'd4);
    apb_write(12'h00C, 32'h0);
    check("R7 write 0 keeps flag", {31'b0, irq_out}, 32'd1);
    apb_write(12'h000, 32'h8);          // stop, keep irq enable
    apb_read(12'h004, d);
    idle(10);
    apb_read(12'h004, d2);
    check("R11 stopped count frozen", d2, d);
    apb_write(12'h00C, 32'h1);
    apb_write(12'h000, 32'h0);
  endtask

  task automatic t_no_irq_en;
    logic [31:0] d;
    apb_write(12'h008, 32'd2);
    apb_write(12'h000, 32'h1);
    idle(30);
    check("R8 irq stays low", {31'b0, irq_out}, 32'd0);
    apb_read(12'h00C, d); check("R8 status stays 0", d, 32'h0);
    apb_write(12'h000, 32'h0);
  endtask

  task automatic t_zero_reload;
    int n;
    logic [31:0] d;
    apb_write(12'h008, 32'd0);
    apb_write(12'h004, 32'd3);
    apb_write(12'h000, 32'h9);
    wait_irq(n);
    check("R6 expiry from count 3", n, 32'd3);
    apb_write(12'h00C, 32'h1);
    idle(30);
    check("R6 no further irq", {31'b0, irq_out}, 32'd0);
    apb_read(12'h004, d); check("R6 count stays 0", d, 32'h0);
    apb_write(12'h000, 32'h0);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    apb_write(12'h008, 32'd100);
    apb_write(12'h000, 32'h1);
    apb_write(12'h004, 32'd7);          // loads 7 despite a tick in that cycle
    apb_write(12'h000, 32'h0);          // two ticks before the stop lands
    apb_read(12'h004, d); check("R11 write beats decrement", d, 32'd5);
    idle(10);
    apb_read(12'h004, d); check("R11 frozen after stop", d, 32'd5);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    apb_write(12'h000, 32'h3);
    apb_write(12'h004, 32'd10);
    idle(20);
    apb_read(12'h004, d); check("R9 gate low holds count", d, 32'd10);
    ext_sig = 1'b1;
    idle(4);
    ext_sig = 1'b0;
    idle(6);
    apb_read(12'h004, d); check("R9 gate high for 4 edges", d, 32'd6);
    apb_write(12'h000, 32'h0);
  endtask

  task automatic t_ext_clock;
    logic [31:0] d;
    apb_write(12'h000, 32'h5);
    apb_write(12'h004, 32'd20);
    idle(10);
    apb_read(12'h004, d); check("R10 no ticks without edges", d, 32'd20);
    for (int i = 0; i < 5; i++) begin
      ext_sig = 1'b1; idle(3);
      ext_sig = 1'b0; idle(3);
    end
    idle(5);
    apb_read(12'h004, d); check("R10 five rising edges", d, 32'd15);
    apb_write(12'h000, 32'h0);
  endtask

  task automatic t_ids;
    logic [31:0] d;
    logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h22, 8'hB8,
                                8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 12; i++) begin
      apb_read(12'hFD0 + 12'(4 * i), d);
      check($sformatf("R12 id word %0d", i), d, {24'b0, exp_id[i]});
    end
    apb_write(12'hFD0, 32'hFF);
    apb_read(12'hFD0, d); check("R12 id write ignored", d, 32'h04);
    apb_write(12'h010, 32'hF);
    apb_read(12'h010, d); check("R12 unmapped read 0", d, 32'h0);
    apb_read(12'hFCC, d); check("R12 unmapped below ids", d, 32'h0);
    apb_read(12'h000, d); check("R12 unmapped write leaves ctrl", d, 32'h0);
    apb_read(12'h004, d); check("R12 unmapped write leaves count", d, 32'd15);
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    t_reset;
    t_ctrl_bits;
    t_load;
    t_periodic;
    t_no_irq_en;
    t_zero_reload;
    t_priority;
    t_gate;
    t_ext_clock;
    t_ids;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule